// File: doc/BRIEF.md
# Six-Source Interrupt Controller

This block gathers six peripheral conditions into one interrupt request for a processor. Two of the conditions are levels that the peripheral holds for as long as they apply: the UART transmit FIFO is empty, and the UART receive FIFO holds data. The other four are events, and the block latches them as pending until software clears them. These four are a push-button press, the counter reaching zero, the timer reaching zero, and a change on a 16-bit general-purpose input port.

Each source has its own enable bit. The interrupt request is high whenever any source is both pending and enabled. Software works through a two-word register interface. Address 0 holds the enable mask, which can be read and written. Address 1 is the pending view, which can be read, and its event bits are cleared by writing 1 to them. The button input is asynchronous, so it passes through a synchroniser before its rising edge is detected.

Top module: `irq_six_top`

## Requirements
- R1: After reset the enable mask reads 0, every event pending bit reads 0, and `irq` is low.
- R2: Bit positions in both registers are fixed as follows: bit 0 is the button, bit 1 is transmit-empty, bit 2 is receive-not-empty, bit 3 is the counter at zero, bit 4 is the timer at zero, and bit 5 is the input change. A write to address 0 replaces the enable mask, and a read of address 0 returns it.
- R3: A read of address 1 returns the live level of `tx_empty` in bit 1 and the live level of `rx_nonempty` in bit 2. These two bits are never latched.
- R4: A rising edge on `cnt_zero` or `tmr_zero` sets pending bit 3 or bit 4 at the next clock edge. A level that stays high does not set the bit again after it has been cleared.
- R5: The button input passes through a two-flop synchroniser followed by a rising-edge detector. A rise on `btn_raw` shows in pending bit 0 after the third clock edge, and not after the second.
- R6: Any difference between `gpin` and its value at the previous clock edge sets pending bit 5. No comparison is made at the first clock edge after reset, so a non-zero port value at reset does not raise the event.
- R7: A write to address 1 clears each event bit (0, 3, 4, 5) whose data bit is 1. Data bits of 0 leave the pending bits unchanged. Writes to bits 1 and 2 have no effect.
- R8: If an event and a clear of the same bit happen in the same cycle, the bit remains set.
- R9: `irq` is the combinational OR, over all six bits, of each pending-view bit ANDed with its enable bit.
- R10: An event is latched even while its enable bit is 0. Enabling it later raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| btn_raw | input | 1 | Asynchronous push-button level |
| tx_empty | input | 1 | Transmit FIFO empty level |
| rx_nonempty | input | 1 | Receive FIFO not-empty level |
| cnt_zero | input | 1 | Counter-at-zero condition |
| tmr_zero | input | 1 | Timer-at-zero condition |
| gpin | input | 16 | General-purpose input port |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 is the enable mask, 1 is the pending view |
| wdata | input | 6 | Write data |
| rdata | output | 6 | Read data for the selected register (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `wr_en`, `addr` and `wdata` are known and stable around every rising clock edge. They also assume that a write targets exactly one register per cycle. The bench drives all inputs just after a falling edge and holds them for a full cycle. As a result, every write and every source transition is seen by exactly one rising edge. The button is the one exception: it is held for several cycles, so the synchroniser's latency is observed in a controlled way rather than as a metastable race.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC    = 6;
    localparam int BIT_BTN = 0;
    localparam int BIT_TXE = 1;
    localparam int BIT_RXN = 2;
    localparam int BIT_CNT = 3;
    localparam int BIT_TMR = 4;
    localparam int BIT_CHG = 5;
    localparam logic [NSRC-1:0] EVT_MASK =
        (NSRC'(1) << BIT_BTN) | (NSRC'(1) << BIT_CNT) |
        (NSRC'(1) << BIT_TMR) | (NSRC'(1) << BIT_CHG);

    typedef struct packed {
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] pend;
    } irq_regs_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sync_d, sync_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sync_d = din;
        end else begin : g_many
            always_comb sync_d = {sync_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/irq_rise.sv
module irq_rise #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = din;
        rise   = din & ~prev_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/irq_chg.sv
module irq_chg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic         chg
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic         armed;
    } chg_st_t;

    chg_st_t st_d, st_q;

    always_comb begin
        st_d.prev  = din;
        st_d.armed = 1'b1;
        chg        = st_q.armed && (din != st_q.prev);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/irq_six_top.sv
module irq_six_top
    import irq_pkg::*;
#(
    parameter int GPIO_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              btn_raw,
    input  logic              tx_empty,
    input  logic              rx_nonempty,
    input  logic              cnt_zero,
    input  logic              tmr_zero,
    input  logic [GPIO_W-1:0] gpin,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [NSRC-1:0]   wdata,
    output logic [NSRC-1:0]   rdata,
    output logic              irq
);
    logic            btn_s, btn_r, gp_chg;
    logic [1:0]      zero_r;
    logic [NSRC-1:0] evt, clr, view;
    irq_regs_t       r_d, r_q;

    irq_sync #(.STAGES(SYNC_STAGES)) u_bsync (
        .clk(clk), .rst_n(rst_n), .din(btn_raw), .dout(btn_s));
    irq_rise #(.W(1)) u_brise (
        .clk(clk), .rst_n(rst_n), .din(btn_s), .rise(btn_r));
    irq_rise #(.W(2)) u_zrise (
        .clk(clk), .rst_n(rst_n), .din({tmr_zero, cnt_zero}), .rise(zero_r));
    irq_chg #(.W(GPIO_W)) u_chg (
        .clk(clk), .rst_n(rst_n), .din(gpin), .chg(gp_chg));

    always_comb begin
        evt          = '0;
        evt[BIT_BTN] = btn_r;
        evt[BIT_CNT] = zero_r[0];
        evt[BIT_TMR] = zero_r[1];
        evt[BIT_CHG] = gp_chg;

        clr   = (wr_en && addr) ? (wdata & EVT_MASK) : '0;
        r_d.en   = (wr_en && !addr) ? wdata : r_q.en;
        r_d.pend = ((r_q.pend & ~clr) | evt) & EVT_MASK;

        view          = r_q.pend;
        view[BIT_TXE] = tx_empty;
        view[BIT_RXN] = rx_nonempty;

        rdata = addr ? view : r_q.en;
        irq   = |(view & r_q.en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr) |=> (r_q.en == $past(wdata)));  // R2
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|r_q.en));  // R9
    AST_LEVEL_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (r_q.pend[BIT_TXE] == 1'b0 && r_q.pend[BIT_RXN] == 1'b0));  // R3

    genvar gi;
    generate
        for (gi = 0; gi < NSRC; gi++) begin : g_ast
            if (EVT_MASK[gi]) begin : g_evt
                AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
                    evt[gi] |=> r_q.pend[gi]);  // R8
                AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                    (r_q.pend[gi] && !(wr_en && addr && wdata[gi])) |=> r_q.pend[gi]);  // R7
            end
        end
    endgenerate
endmodule

// File: tb/irq_six_top_test.sv
module irq_six_top_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        btn_raw = 1'b0, tx_empty = 1'b0, rx_nonempty = 1'b0;
    logic        cnt_zero = 1'b0, tmr_zero = 1'b0;
    logic [15:0] gpin = 16'hA5A5;
    logic        wr_en = 1'b0, addr = 1'b0;
    logic [5:0]  wdata = '0;
    logic [5:0]  rdata;
    logic        irq;
    int total = 0, bad = 0;
    bit finished = 0;

    irq_six_top uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [5:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0; wdata = '0;
    endtask

    function automatic int pend_now();
        return int'(rdata);
    endfunction

    task automatic rd(input logic a, output int v);
        addr = a; #1; v = int'(rdata);
    endtask

    task automatic zero_evt(input int b, input string req);
        int v;
        wr(1'b0, 6'd0);
        if (b == 3) cnt_zero = 1'b1; else tmr_zero = 1'b1;
        tick();
        rd(1'b1, v);
        chk(req, (v >> b) & 1, 1);
        chk("R10 latched while disabled", int'(irq), 0);
        wr(1'b1, 6'(1 << b));
        tick();
        rd(1'b1, v);
        chk({req, " held level no reset"}, (v >> b) & 1, 0);
        wr(1'b0, 6'(1 << b));
        #1 chk("R9 cleared gives no irq", int'(irq), 0);
        if (b == 3) cnt_zero = 1'b0; else tmr_zero = 1'b0;
        tick();
        if (b == 3) cnt_zero = 1'b1; else tmr_zero = 1'b1;
        tick();
        #1 chk("R10 enabled pending raises irq", int'(irq), 1);
        if (b == 3) cnt_zero = 1'b0; else tmr_zero = 1'b0;
        wr(1'b1, 6'(1 << b));
        wr(1'b0, 6'd0);
    endtask

    initial begin
        int v;
        repeat (3) tick();
        rst_n = 1'b1;
        rd(1'b0, v); chk("R1 enable reset", v, 0);
        rd(1'b1, v); chk("R1 pending reset", v, 0);
        chk("R1 irq reset", int'(irq), 0);
        tick(); tick();
        rd(1'b1, v); chk("R6 no change event at first edge", (v >> 5) & 1, 0);

        // R9 / R2 / R3 exhaustive mask by level sweep
        for (int m = 0; m < 64; m++) begin
            wr(1'b0, 6'(m));
            rd(1'b0, v); chk("R2 enable readback", v, m);
            for (int lv = 0; lv < 4; lv++) begin
                tx_empty = lv[0]; rx_nonempty = lv[1];
                rd(1'b1, v);
                chk("R3 live levels", v, (lv[1] << 2) | (lv[0] << 1));
                chk("R9 irq level sweep", int'(irq),
                    (((m >> 1) & lv & 1) | ((m >> 2) & (lv >> 1) & 1)));
            end
        end
        tx_empty = 1'b0; rx_nonempty = 1'b0;
        wr(1'b0, 6'd0);

        zero_evt(3, "R4 counter");
        zero_evt(4, "R4 timer");

        // R5 button latency
        btn_raw = 1'b1;
        tick(); tick();
        rd(1'b1, v); chk("R5 not after two edges", v & 1, 0);
        tick();
        rd(1'b1, v); chk("R5 set after three edges", v & 1, 1);
        btn_raw = 1'b0;
        wr(1'b1, 6'h01);
        rd(1'b1, v); chk("R7 button cleared", v & 1, 0);

        // R6 each gpin bit
        for (int b = 0; b < 16; b++) begin
            gpin = gpin ^ (16'd1 << b);
            tick();
            rd(1'b1, v); chk("R6 bit change", (v >> 5) & 1, 1);
            wr(1'b1, 6'h20);
            tick();
            rd(1'b1, v); chk("R6 no change stays clear", (v >> 5) & 1, 0);
        end

        // R7 write zero / write level bits
        gpin = ~gpin; tick();
        tx_empty = 1'b1;
        wr(1'b1, 6'h00);
        rd(1'b1, v); chk("R7 zero write keeps", (v >> 5) & 1, 1);
        wr(1'b1, 6'h02);
        rd(1'b1, v); chk("R7 level bit unaffected", (v >> 1) & 1, 1);
        tx_empty = 1'b0;
        wr(1'b1, 6'h20);

        // R8 set beats clear
        cnt_zero = 1'b1; tick(); cnt_zero = 1'b0; tick();
        rd(1'b1, v); chk("R8 precondition", (v >> 3) & 1, 1);
        cnt_zero = 1'b1;
        wr(1'b1, 6'h08);
        rd(1'b1, v); chk("R8 set wins", (v >> 3) & 1, 1);
        cnt_zero = 1'b0;
        wr(1'b1, 6'h08);
        rd(1'b1, v); chk("R7 clear after", (v >> 3) & 1, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule